// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Mailbox Interrupts

This block is a true dual-port synchronous byte memory with two symmetric ports, left and right. Each port has an active-low select, an active-low write strobe, an active-low output enable, an address and separate write and read data buses. Every operation is sampled on the rising edge of one shared clock. Read data is registered, so it appears on the read bus one cycle after the request.

The two highest addresses are also mailboxes for passing messages between the ports. The left port sends by writing the highest address (all ones). That write drives the right port's active-low interrupt low. The right port acknowledges by reading the same location with its output enable low, which releases the interrupt. In the other direction, the right port writes the second-highest address (all ones except bit 0). That raises the left port's interrupt, and a left read of that address clears it. Both mailbox locations still store their byte like any other address. Each port has a hold input. While it is high, that port's mailbox write cannot set a flag and its mailbox read cannot clear one. The memory access itself still takes place.

The address width is a parameter. Setting ADDR_W to 16 gives the full 64K x 8 array. The default is smaller so that elaboration stays light, and the mailbox addresses always follow the top of whatever depth is chosen.

Top module: `dpm_mailbox_top`

## Requirements
- R1: A left write (l_cs_n=0, l_we_n=0) to address all-ones with l_hold=0 drives r_irq_n low from the next clock edge.
- R2: A right read (r_cs_n=0, r_we_n=1, r_oe_n=0) of address all-ones with r_hold=0 drives r_irq_n high from the next clock edge.
- R3: A right write to address all-ones-but-bit-0 with r_hold=0 drives l_irq_n low. A left read of that address with l_oe_n=0 and l_hold=0 drives it high again.
- R4: While a port's hold input is 1, its mailbox write leaves the peer's interrupt unchanged and its mailbox read leaves its own interrupt unchanged.
- R5: An interrupt does not change in a cycle that has none of its set or clear conditions. Examples are an inactive select, a read with output enable high, a read of the slot by the sending port, and a write of the slot by the receiving port.
- R6: While rst is 1 at a clock edge, both l_irq_n and r_irq_n are 1 after that edge, and both read buses are 0.
- R7: Every address, including the two mailbox slots, stores the written byte. A read returns it on the read bus one cycle after the request.
- R8: If a set and a clear of the same interrupt happen in one cycle, the interrupt ends up asserted (low).
- R9: If both ports write the same address in one cycle, the left port's byte is stored.
- R10: A read of an address that is being written in the same cycle returns the byte held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of flags and read buses |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, low = write, high = read |
| l_oe_n | input | 1 | Left output enable, active low; qualifies the mailbox clear |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_hold | input | 1 | Left hold, blocks left-originated flag changes |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, low = write, high = read |
| r_oe_n | input | 1 | Right output enable, active low; qualifies the mailbox clear |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_hold | input | 1 | Right hold, blocks right-originated flag changes |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The hardest cases to reach from the ports need the two ports to act in the same cycle. One is a set and a clear landing on one flag together. The others are two writes to one address, and a read that overlaps a write. The bench therefore drives both ports in the same cycle at a falling edge, so that one rising edge samples both requests. It then reads the flag and the stored bytes afterwards through the normal read path. The hold and "no effect" cases are checked by first putting a flag in a known asserted state and then observing the interrupt pin right after the blocked or irrelevant access.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_act_t;

    function automatic port_op_e decode_op(input logic cs_n, input logic we_n);
        if (cs_n)
            return OP_IDLE;
        return we_n ? OP_READ : OP_WRITE;
    endfunction

    // Set has priority over clear.
    function automatic logic next_flag(input logic cur, input flag_act_t act);
        if (act.set)
            return 1'b1;
        if (act.clr)
            return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
    import dpm_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter bit IS_RIGHT = 1'b0
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hold,
    output logic              mem_we,
    output logic              mem_re,
    output logic              send,
    output logic              take
);
    localparam logic [ADDR_W-1:0] SLOT_HI = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SLOT_LO = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] TX_SLOT = IS_RIGHT ? SLOT_LO : SLOT_HI;
    localparam logic [ADDR_W-1:0] RX_SLOT = IS_RIGHT ? SLOT_HI : SLOT_LO;

    port_op_e op;

    always_comb begin
        op     = decode_op(cs_n, we_n);
        mem_we = (op == OP_WRITE);
        mem_re = (op == OP_READ);
        send   = mem_we && (addr == TX_SLOT) && !hold;
        take   = mem_re && !oe_n && (addr == RX_SLOT) && !hold;
    end
endmodule

// File: rtl/dpm_mbox_flag.sv
module dpm_mbox_flag
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    flag_act_t act;
    logic      flag_q;

    assign act   = '{set: set_req, clr: clr_req};
    assign irq_n = ~flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= next_flag(flag_q, act);
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_req |=> !irq_n);
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_req) |=> irq_n);
    p_hold_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (!set_req && !clr_req) |=> $stable(irq_n));
endmodule

// File: rtl/dpm_storage.sv
module dpm_storage #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_we,
    input  logic              l_re,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_we,
    input  logic              r_re,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Right first, left last: left wins a same-address collision.
    always_ff @(posedge clk) begin
        if (r_we)
            mem[r_addr] <= r_wdata;
        if (l_we)
            mem[l_addr] <= l_wdata;
    end

    // Reads see the pre-edge contents (old data on collision).
    always_ff @(posedge clk) begin
        if (rst) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_re)
                l_rdata <= mem[l_addr];
            if (r_re)
                r_rdata <= mem[r_addr];
        end
    end

    p_left_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (l_we && r_we && l_addr == r_addr) |=> mem[$past(l_addr)] == $past(l_wdata));
endmodule

// File: rtl/dpm_mailbox_top.sv
module dpm_mailbox_top #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_hold,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_hold,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int NPORT = 2;

    logic [NPORT-1:0] p_cs_n, p_we_n, p_oe_n, p_hold;
    logic [NPORT-1:0] p_mem_we, p_mem_re, p_send, p_take;
    logic [NPORT-1:0][ADDR_W-1:0] p_addr;
    logic [NPORT-1:0] irq_n_v;

    // index 0 = left, index 1 = right
    assign p_cs_n = {r_cs_n, l_cs_n};
    assign p_we_n = {r_we_n, l_we_n};
    assign p_oe_n = {r_oe_n, l_oe_n};
    assign p_hold = {r_hold, l_hold};
    assign p_addr = {r_addr, l_addr};

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        dpm_port_decode #(.ADDR_W(ADDR_W), .IS_RIGHT(g == 1)) u_dec (
            .cs_n   (p_cs_n[g]),
            .we_n   (p_we_n[g]),
            .oe_n   (p_oe_n[g]),
            .addr   (p_addr[g]),
            .hold   (p_hold[g]),
            .mem_we (p_mem_we[g]),
            .mem_re (p_mem_re[g]),
            .send   (p_send[g]),
            .take   (p_take[g])
        );

        // Flag g interrupts port g: set by the peer, cleared by port g.
        dpm_mbox_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_req (p_send[NPORT-1-g]),
            .clr_req (p_take[g]),
            .irq_n   (irq_n_v[g])
        );
    end

    assign l_irq_n = irq_n_v[0];
    assign r_irq_n = irq_n_v[1];

    dpm_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .l_we    (p_mem_we[0]),
        .l_re    (p_mem_re[0]),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_we    (p_mem_we[1]),
        .r_re    (p_mem_re[1]),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

    p_reset_idle_r6: assert property (@(posedge clk)
        rst |=> (l_irq_n && r_irq_n));
    p_lhold_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (l_hold && r_irq_n) |=> r_irq_n);
    p_rhold_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (r_hold && l_irq_n) |=> l_irq_n);
    p_left_send_r1: assert property (@(posedge clk) disable iff (rst)
        (!l_cs_n && !l_we_n && l_addr == {ADDR_W{1'b1}} && !l_hold) |=> !r_irq_n);
    p_right_send_r3: assert property (@(posedge clk) disable iff (rst)
        (!r_cs_n && !r_we_n && r_addr == {{(ADDR_W-1){1'b1}}, 1'b0} && !r_hold) |=> !l_irq_n);
endmodule

// File: tb/dpm_mailbox_top_tb.sv
module dpm_mailbox_top_tb_top;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam logic [AW-1:0] HI = {AW{1'b1}};
    localparam logic [AW-1:0] LO = {{(AW-1){1'b1}}, 1'b0};

    logic clk = 1'b0;
    logic rst;
    logic l_cs_n, l_we_n, l_oe_n, l_hold;
    logic r_cs_n, r_we_n, r_oe_n, r_hold;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dpm_mailbox_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_hold(l_hold), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_hold(r_hold), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic idle();
        l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_addr = '0; l_wdata = '0; l_hold = 0;
        r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_addr = '0; r_wdata = '0; r_hold = 0;
    endtask

    // Inputs are set at a falling edge; one rising edge samples them.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic lwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_cs_n = 0; l_we_n = 0; l_addr = a; l_wdata = d;
    endtask
    task automatic rwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_cs_n = 0; r_we_n = 0; r_addr = a; r_wdata = d;
    endtask
    task automatic lrd(input logic [AW-1:0] a, input logic oe_n);
        l_cs_n = 0; l_we_n = 1; l_oe_n = oe_n; l_addr = a;
    endtask
    task automatic rrd(input logic [AW-1:0] a, input logic oe_n);
        r_cs_n = 0; r_we_n = 1; r_oe_n = oe_n; r_addr = a;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        check("R6 l_irq_n after reset", l_irq_n, 1);
        check("R6 r_irq_n after reset", r_irq_n, 1);
        check("R6 l_rdata after reset", l_rdata, 0);
        check("R6 r_rdata after reset", r_rdata, 0);
    endtask

    task automatic t_left_to_right();
        lwr(HI, 8'hA5); step();
        check("R1 r_irq_n after left send", r_irq_n, 0);
        check("R1 l_irq_n untouched", l_irq_n, 1);
        rrd(HI, 0); step();
        check("R2 r_irq_n after right take", r_irq_n, 1);
        check("R7 right reads slot byte", r_rdata, 8'hA5);
    endtask

    task automatic t_right_to_left();
        rwr(LO, 8'h3C); step();
        check("R3 l_irq_n after right send", l_irq_n, 0);
        check("R3 r_irq_n untouched", r_irq_n, 1);
        lrd(LO, 0); step();
        check("R3 l_irq_n after left take", l_irq_n, 1);
        check("R7 left reads slot byte", l_rdata, 8'h3C);
    endtask

    task automatic t_hold();
        l_hold = 1; lwr(HI, 8'h01); step();
        check("R4 left hold blocks set", r_irq_n, 1);
        lwr(HI, 8'h02); step();
        check("R4 set without hold", r_irq_n, 0);
        r_hold = 1; rrd(HI, 0); step();
        check("R4 right hold blocks clear", r_irq_n, 0);
        check("R7 read still done under hold", r_rdata, 8'h02);
        r_hold = 1; rwr(LO, 8'h07); step();
        check("R4 right hold blocks left set", l_irq_n, 1);
        rrd(HI, 0); step();
        check("R2 clear after hold", r_irq_n, 1);
    endtask

    task automatic t_ignore();
        lwr(HI, 8'h55); step();
        check("R1 set before ignore tests", r_irq_n, 0);
        rrd(HI, 1); step();
        check("R5 read with oe high", r_irq_n, 0);
        r_cs_n = 1; r_we_n = 1; r_oe_n = 0; r_addr = HI; step();
        check("R5 deselected read", r_irq_n, 0);
        lrd(HI, 0); step();
        check("R5 sender reads own slot", r_irq_n, 0);
        rwr(HI, 8'h66); step();
        check("R5 receiver writes slot", r_irq_n, 0);
        check("R5 left flag unaffected", l_irq_n, 1);
        rrd(HI - 2, 0); step();
        check("R5 read of other address", r_irq_n, 0);
        rrd(HI, 0); step();
        check("R2 clear returns last byte", r_rdata, 8'h66);
        check("R2 cleared", r_irq_n, 1);
    endtask

    task automatic t_set_wins();
        lwr(HI, 8'h10); step();
        lwr(HI, 8'h20); rrd(HI, 0); step();
        check("R8 right flag set wins", r_irq_n, 0);
        check("R10 take sees old slot byte", r_rdata, 8'h10);
        rwr(LO, 8'h30); lrd(LO, 0); step();
        check("R8 left flag set wins", l_irq_n, 0);
        lrd(LO, 0); rrd(HI, 0); step();
        check("R3 left cleared", l_irq_n, 1);
        check("R2 right cleared", r_irq_n, 1);
    endtask

    task automatic t_collide();
        lwr(10'd5, 8'hC1); rwr(10'd5, 8'hD2); step();
        rrd(10'd5, 0); lrd(10'd5, 0); step();
        check("R9 right sees left byte", r_rdata, 8'hC1);
        check("R9 left sees left byte", l_rdata, 8'hC1);
    endtask

    task automatic t_read_old();
        lwr(10'd7, 8'h11); step();
        lwr(10'd7, 8'h22); rrd(10'd7, 0); step();
        check("R10 right read during write", r_rdata, 8'h11);
        rwr(10'd7, 8'h33); lrd(10'd7, 0); step();
        check("R10 left read during write", l_rdata, 8'h22);
        rrd(10'd7, 0); step();
        check("R7 new byte after write", r_rdata, 8'h33);
    endtask

    task automatic t_reset_mid();
        lwr(HI, 8'h44); rwr(LO, 8'h45); step();
        check("R1 pre-reset right set", r_irq_n, 0);
        check("R3 pre-reset left set", l_irq_n, 0);
        rst = 1'b1; step(); rst = 1'b0;
        check("R6 l_irq_n after mid reset", l_irq_n, 1);
        check("R6 r_irq_n after mid reset", r_irq_n, 1);
    endtask

    initial begin
        rst = 1'b1;
        idle();
        @(negedge clk);
        t_reset();
        t_left_to_right();
        t_right_to_left();
        t_hold();
        t_ignore();
        t_set_wins();
        t_collide();
        t_read_old();
        t_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule